// File: doc/BRIEF.md
# DDR2 Power-Up Command Sequencer

This block drives the fixed power-up command sequence that DDR2 memory needs before it can be used. Before each phase it writes a 3-bit command code. It then issues one-cycle trigger accesses, each with an address. The memory controller beside it turns those accesses into bus cycles on the DRAM. Every phase first addresses a base target at address zero. It then addresses each populated rank, in ascending rank order. A rank counts as populated when its 8-bit start field is nonzero, and the rank's target address is that field shifted up by 26 bits.

The sequence is started by a single-cycle pulse. The sequencer counts clock cycles to produce the long microsecond waits, using a parameter that gives the number of cycles per microsecond. It builds the final mode-register word from the CAS-latency selector, the write-recovery selector and the burst-length flag. At the end it loads the refresh counter, which enables periodic refresh, and it raises a done flag. The rank fields and the timing selectors must be held stable while a sequence is running.

Top module: `ddr2_pwrup_seq`

## Requirements
- R1: `cmd_o` carries 0 for normal operation, 1 for no-op, 2 for precharge-all, 3 for mode-register set and 4 for refresh. It changes only in the cycle in which the first access of a phase is strobed, and it then holds until the next phase.
- R2: The phases run in this order: no-op at offset 0, precharge at 0, mode set at 0x12000, mode set at 0x800, precharge at 0, refresh at 0, mode set at the computed word, normal at 0, normal at 0x30.
- R3: In each phase the targets are the base (address 0) and then every rank whose 8-bit field (rank r in bits 8r+7:8r of `rank_start_i`) is nonzero, in ascending r. The target address is the field shifted left by 26 and truncated to 32 bits. The first access to a target is at target + offset.
- R4: Each target gets follow-up accesses after its first access. A mode set at offset 0x12000 adds one at target + 0x800. Any other mode set adds target + 0x121c20 and then target + 0x120020. The refresh phase adds 8 accesses at the target address itself.
- R5: Each strobe lasts exactly one cycle. It is followed by one idle cycle, or by GAP_US*CYC_PER_US idle cycles after each of the 8 refresh follow-ups. One idle cycle, in which the command is loaded, precedes the first access of every phase. That cycle is the one that follows the cycle in which the start pulse is sampled.
- R6: After the idle cycle of the last no-op access, INIT_US*CYC_PER_US further idle cycles pass before the precharge phase begins.
- R7: The computed mode word is the OR of three terms. The first is 0x8 when `bl8_i` is 1. The second is 0x150, 0x1d0, 0x250 or 0x2d0 for `cas_sel_i` 0 to 3. The third is 0x1000, 0x100000, 0x101000 or 0x2000 for `wr_sel_i` 0 to 3.
- R8: `refresh_o` is cleared when a start is accepted and becomes 0x32 in the same cycle that `done_o` rises.
- R9: `done_o` rises in the cycle after the idle cycle of the final access. It stays high until a start is accepted. A start pulse that arrives while a sequence runs has no effect.
- R10: After reset, `cmd_o` is 0, `acc_stb_o` is 0, `done_o` is 0 and `refresh_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| rank_start_i | input | NUM_RANKS*8 | Per-rank start fields; a zero field means the rank is absent |
| cas_sel_i | input | 2 | CAS latency selector |
| wr_sel_i | input | 2 | Write recovery selector |
| bl8_i | input | 1 | 1 selects burst length 8, 0 selects burst length 4 |
| cmd_o | output | 3 | Current command code |
| acc_stb_o | output | 1 | One-cycle trigger access strobe |
| acc_addr_o | output | 32 | Trigger access address, valid while the strobe is high |
| done_o | output | 1 | Sequence complete |
| refresh_o | output | 8 | Refresh counter load value |

## Verification
A wrong phase index shows up on `cmd_o` and in the offset of the next strobed address. It is visible within one cycle of that phase's first access. A rank scan that skips a rank or revisits one moves every later strobe by at least two cycles, so the per-cycle comparison against the reference timeline reports it at once. A gap or power-up wait counter that is off by even one cycle shifts every strobe that follows. A wrong mode-word term appears only on the addresses of the seventh phase, so several selector combinations are needed to reach each table entry.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [2:0] {
    CMD_NORMAL    = 3'd0,
    CMD_NOP       = 3'd1,
    CMD_PRECHARGE = 3'd2,
    CMD_MODE      = 3'd3,
    CMD_REFRESH   = 3'd4
  } dram_cmd_e;

  typedef enum logic [2:0] {ST_IDLE, ST_SET, ST_ACC, ST_WAIT, ST_DELAY} seq_state_e;

  localparam logic [3:0]  LAST_STEP   = 4'd8;
  localparam logic [31:0] OFF_DLL_ON  = 32'h0001_2000;
  localparam logic [31:0] OFF_DLL_RST = 32'h0000_0800;
  localparam logic [31:0] OFF_TAIL    = 32'h0000_0030;
  localparam logic [31:0] MODE_EXT_A  = 32'h0012_1c20;
  localparam logic [31:0] MODE_EXT_B  = 32'h0012_0020;

  // command code issued by each phase of the power-up order
  function automatic dram_cmd_e step_cmd(input logic [3:0] s);
    case (s)
      4'd0:             return CMD_NOP;
      4'd1, 4'd4:       return CMD_PRECHARGE;
      4'd2, 4'd3, 4'd6: return CMD_MODE;
      4'd5:             return CMD_REFRESH;
      default:          return CMD_NORMAL;
    endcase
  endfunction

  // final mode word: burst-length bit ORed with CAS and write-recovery terms
  function automatic logic [31:0] mode_word(input logic bl8, input logic [1:0] cas,
                                            input logic [1:0] wr);
    logic [31:0] c_t, w_t;
    case (cas)
      2'd0: c_t = 32'h150;
      2'd1: c_t = 32'h1d0;
      2'd2: c_t = 32'h250;
      default: c_t = 32'h2d0;
    endcase
    case (wr)
      2'd0: w_t = 32'h0000_1000;
      2'd1: w_t = 32'h0010_0000;
      2'd2: w_t = 32'h0010_1000;
      default: w_t = 32'h0000_2000;
    endcase
    return (bl8 ? 32'h8 : 32'h0) | c_t | w_t;
  endfunction

  function automatic logic [31:0] step_offset(input logic [3:0] s, input logic [31:0] mw);
    case (s)
      4'd2:    return OFF_DLL_ON;
      4'd3:    return OFF_DLL_RST;
      4'd6:    return mw;
      4'd8:    return OFF_TAIL;
      default: return 32'h0;
    endcase
  endfunction

  // offset of follow-up access number sub (1-based) relative to the target
  function automatic logic [31:0] extra_offset(input dram_cmd_e c, input logic [31:0] off,
                                               input logic [3:0] sub);
    if (c == CMD_MODE) begin
      if (off == OFF_DLL_ON) return OFF_DLL_RST;
      return (sub == 4'd1) ? MODE_EXT_A : MODE_EXT_B;
    end
    return 32'h0;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rank_pick.sv
module rank_pick #(
  parameter int NUM_RANKS = 4,
  parameter int FIELD_W   = 8,
  parameter int TW        = 3
) (
  input  logic [NUM_RANKS*FIELD_W-1:0] fields_i,
  input  logic [TW-1:0]                cur_i,
  output logic                         found_o,
  output logic [TW-1:0]                next_o,
  output logic [FIELD_W-1:0]           sel_o
);
  // target 0 is the base; target r+1 is rank r
  always_comb begin
    found_o = 1'b0;
    next_o  = '0;
    sel_o   = '0;
    for (int r = NUM_RANKS - 1; r >= 0; r--) begin
      if ((fields_i[r*FIELD_W +: FIELD_W] != '0) && (int'(cur_i) < r + 1)) begin
        found_o = 1'b1;
        next_o  = TW'(r + 1);
      end
      if (int'(cur_i) == r + 1) sel_o = fields_i[r*FIELD_W +: FIELD_W];
    end
  end
endmodule

// File: rtl/ddr2_pwrup_seq.sv
module ddr2_pwrup_seq
  import ddr2_init_pkg::*;
#(
  parameter int         NUM_RANKS  = 4,
  parameter int         FIELD_W    = 8,
  parameter int         ADDR_W     = 32,
  parameter int         RANK_SHIFT = 26,
  parameter int         CYC_PER_US = 100,
  parameter int         INIT_US    = 200,
  parameter int         GAP_US     = 100,
  parameter int         REF_BURST  = 8,
  parameter logic [7:0] REF_LOAD   = 8'h32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [NUM_RANKS*FIELD_W-1:0] rank_start_i,
  input  logic [1:0]                   cas_sel_i,
  input  logic [1:0]                   wr_sel_i,
  input  logic                         bl8_i,
  output logic [2:0]                   cmd_o,
  output logic                         acc_stb_o,
  output logic [ADDR_W-1:0]            acc_addr_o,
  output logic                         done_o,
  output logic [7:0]                   refresh_o
);
  localparam int INIT_CYC = INIT_US * CYC_PER_US;
  localparam int GAP_CYC  = GAP_US * CYC_PER_US;
  localparam int MAX_CYC  = (INIT_CYC > GAP_CYC) ? INIT_CYC : GAP_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam int TW       = $clog2(NUM_RANKS + 1);
  localparam int SUB_W    = 4;

  seq_state_e         state_q;
  logic [3:0]         step_q;
  logic [TW-1:0]      tgt_q;
  logic [SUB_W-1:0]   sub_q;
  dram_cmd_e          cmd_q;
  logic               done_q;
  logic [7:0]         ref_q;

  // named internal events
  dram_cmd_e          cur_cmd;
  logic [31:0]        mw, cur_off;
  logic [SUB_W-1:0]   n_ext;
  logic               more_sub, rank_found, step_end, seq_end, in_gap, wait_done;
  logic [TW-1:0]      rank_next;
  logic [FIELD_W-1:0] tgt_field;
  logic [ADDR_W-1:0]  tgt_base;
  logic               tmr_load, tmr_zero;
  logic [CNT_W-1:0]   tmr_val;

  assign cur_cmd = step_cmd(step_q);
  assign mw      = mode_word(bl8_i, cas_sel_i, wr_sel_i);
  assign cur_off = step_offset(step_q, mw);

  always_comb begin
    case (cur_cmd)
      CMD_MODE:    n_ext = (cur_off == OFF_DLL_ON) ? SUB_W'(1) : SUB_W'(2);
      CMD_REFRESH: n_ext = SUB_W'(REF_BURST);
      default:     n_ext = '0;
    endcase
  end

  rank_pick #(.NUM_RANKS(NUM_RANKS), .FIELD_W(FIELD_W), .TW(TW)) u_pick (
    .fields_i (rank_start_i),
    .cur_i    (tgt_q),
    .found_o  (rank_found),
    .next_o   (rank_next),
    .sel_o    (tgt_field)
  );

  assign more_sub  = (sub_q < n_ext);
  assign step_end  = !more_sub && !rank_found;
  assign seq_end   = step_end && (step_q == LAST_STEP);
  assign in_gap    = (cur_cmd == CMD_REFRESH) && (sub_q != '0);
  assign wait_done = (state_q == ST_WAIT) && tmr_zero;

  assign tmr_load = (state_q == ST_ACC) || (wait_done && step_end && (step_q == 4'd0));
  assign tmr_val  = (state_q == ST_ACC) ? (in_gap ? CNT_W'(GAP_CYC - 1) : '0)
                                        : CNT_W'(INIT_CYC - 1);

  seq_timer #(.W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  assign tgt_base   = ADDR_W'(tgt_field) << RANK_SHIFT;
  assign acc_addr_o = tgt_base + ADDR_W'((sub_q == '0) ? cur_off
                                         : extra_offset(cur_cmd, cur_off, sub_q));
  assign acc_stb_o  = (state_q == ST_ACC);
  assign cmd_o      = cmd_q;
  assign done_o     = done_q;
  assign refresh_o  = ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      tgt_q   <= '0;
      sub_q   <= '0;
      cmd_q   <= CMD_NORMAL;
      done_q  <= 1'b0;
      ref_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          step_q  <= '0;
          tgt_q   <= '0;
          sub_q   <= '0;
          done_q  <= 1'b0;
          ref_q   <= '0;
          state_q <= ST_SET;
        end
        ST_SET: begin
          cmd_q   <= cur_cmd;
          state_q <= ST_ACC;
        end
        ST_ACC: state_q <= ST_WAIT;
        ST_WAIT: if (tmr_zero) begin
          if (more_sub) begin
            sub_q   <= sub_q + 1'b1;
            state_q <= ST_ACC;
          end else if (rank_found) begin
            tgt_q   <= rank_next;
            sub_q   <= '0;
            state_q <= ST_ACC;
          end else if (seq_end) begin
            done_q  <= 1'b1;
            ref_q   <= REF_LOAD;
            state_q <= ST_IDLE;
          end else begin
            step_q  <= step_q + 4'd1;
            tgt_q   <= '0;
            sub_q   <= '0;
            state_q <= (step_q == 4'd0) ? ST_DELAY : ST_SET;
          end
        end
        ST_DELAY: if (tmr_zero) state_q <= ST_SET;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_CMD_HELD:    assert property (@(posedge clk) disable iff (!rst_n)
                     acc_stb_o |=> $stable(cmd_o));                        // R1
  AST_STB_PULSE:   assert property (@(posedge clk) disable iff (!rst_n)
                     acc_stb_o |=> !acc_stb_o);                            // R5
  AST_REF_GATED:   assert property (@(posedge clk) disable iff (!rst_n)
                     (refresh_o != 8'h00) |-> done_o);                     // R8
  AST_REF_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
                     $rose(done_o) |-> (refresh_o == REF_LOAD));           // R8
  AST_DONE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n)
                     done_o |-> !acc_stb_o);                               // R9
  AST_DONE_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
                     (done_o && !start_i) |=> done_o);                     // R9
endmodule

// File: tb/sim_ddr2_pwrup_seq.sv
module sim_ddr2_pwrup_seq;
  localparam int CPU    = 2;
  localparam int INIT_C = 200 * CPU;
  localparam int GAP_C  = 100 * CPU;

  logic        clk = 1'b0;
  logic        rst_n, start_i, bl8_i;
  logic [31:0] rank_start_i;
  logic [1:0]  cas_sel_i, wr_sel_i;
  logic [2:0]  cmd_o;
  logic        acc_stb_o, done_o;
  logic [31:0] acc_addr_o;
  logic [7:0]  refresh_o;

  always #5 clk = ~clk;

  ddr2_pwrup_seq #(.CYC_PER_US(CPU)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rank_start_i(rank_start_i),
    .cas_sel_i(cas_sel_i), .wr_sel_i(wr_sel_i), .bl8_i(bl8_i), .cmd_o(cmd_o),
    .acc_stb_o(acc_stb_o), .acc_addr_o(acc_addr_o), .done_o(done_o), .refresh_o(refresh_o)
  );

  typedef struct {
    bit          stb;
    logic [31:0] addr;
    logic [2:0]  cmd;
    bit          done;
    logic [7:0]  rf;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [2:0]  m_cmd = 3'd0;
  bit          m_done = 1'b0;
  logic [7:0]  m_ref = 8'h00;
  int          checks = 0, errors = 0;
  bit          chk_en = 1'b0, finished = 1'b0;

  function automatic void check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endfunction

  function automatic void push(bit stb, logic [31:0] a, string tag);
    q.push_back('{stb, a, m_cmd, 1'b0, 8'h00, tag});
  endfunction

  function automatic void idle(int n, string tag);
    for (int i = 0; i < n; i++) push(1'b0, 32'h0, tag);
  endfunction

  // behavioural timeline of one full power-up run
  function automatic void build_run();
    int          codes[9];
    logic [31:0] offs[9];
    logic [31:0] wrtab[4];
    logic [31:0] mw;
    logic [31:0] bases[$];
    codes = '{1, 2, 3, 3, 2, 4, 3, 0, 0};
    wrtab = '{32'h1000, 32'h100000, 32'h101000, 32'h2000};
    mw = (bl8_i ? 32'h8 : 32'h0) | (32'h150 + 32'h80 * 32'(cas_sel_i)) | wrtab[wr_sel_i];
    offs = '{32'h0, 32'h0, 32'h12000, 32'h800, 32'h0, 32'h0, mw, 32'h0, 32'h30};
    bases.push_back(32'h0);
    for (int r = 0; r < 4; r++)
      if (rank_start_i[r*8 +: 8] != 8'h0) bases.push_back({24'h0, rank_start_i[r*8 +: 8]} << 26);
    for (int s = 0; s < 9; s++) begin
      push(1'b0, 32'h0, "R2");
      m_cmd = 3'(codes[s]);
      foreach (bases[b]) begin
        push(1'b1, bases[b] + offs[s], (s == 6) ? "R7" : "R3");
        idle(1, "R5");
        if (codes[s] == 3) begin
          if (offs[s] == 32'h12000) begin
            push(1'b1, bases[b] + 32'h800, "R4"); idle(1, "R5");
          end else begin
            push(1'b1, bases[b] + 32'h121c20, "R4"); idle(1, "R5");
            push(1'b1, bases[b] + 32'h120020, "R4"); idle(1, "R5");
          end
        end
        if (codes[s] == 4)
          for (int k = 0; k < 8; k++) begin
            push(1'b1, bases[b], "R4"); idle(GAP_C, "R5");
          end
      end
      if (s == 0) idle(INIT_C, "R6");
    end
    m_done = 1'b1;
    m_ref  = 8'h32;
  endfunction

  // compare against the reference every cycle, away from the clock edge
  always @(posedge clk) begin
    exp_t e;
    #3;
    if (chk_en) begin
      if (q.size() > 0) e = q.pop_front();
      else e = '{1'b0, 32'h0, m_cmd, m_done, m_ref, "R9"};
      check(acc_stb_o == e.stb, e.tag, "strobe", 32'(acc_stb_o), 32'(e.stb));
      if (e.stb) check(acc_addr_o == e.addr, e.tag, "address", acc_addr_o, e.addr);
      check(cmd_o == e.cmd, "R1 R2", "command", 32'(cmd_o), 32'(e.cmd));
      check(done_o == e.done, "R9", "done", 32'(done_o), 32'(e.done));
      check(refresh_o == e.rf, "R8", "refresh", 32'(refresh_o), 32'(e.rf));
    end
  end

  task automatic run(input logic [31:0] fields, input logic [1:0] cas, input logic [1:0] wr,
                     input bit bl8, input bit poke_busy);
    @(negedge clk);
    rank_start_i = fields; cas_sel_i = cas; wr_sel_i = wr; bl8_i = bl8;
    @(negedge clk);
    start_i = 1'b1;
    build_run();
    @(negedge clk);
    start_i = 1'b0;
    if (poke_busy) begin
      // R9: a start while busy must leave the timeline untouched
      repeat (60) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (INIT_C + 40) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; rank_start_i = 32'h0;
    cas_sel_i = 2'd0; wr_sel_i = 2'd0; bl8_i = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(cmd_o == 3'd0, "R10", "reset command", 32'(cmd_o), 32'h0);
    check(acc_stb_o == 1'b0, "R10", "reset strobe", 32'(acc_stb_o), 32'h0);
    check(done_o == 1'b0, "R10", "reset done", 32'(done_o), 32'h0);
    check(refresh_o == 8'h0, "R10", "reset refresh", 32'(refresh_o), 32'h0);
    rst_n = 1'b1;
    chk_en = 1'b1;
    repeat (3) @(negedge clk);
    run(32'h03_02_00_01, 2'd2, 2'd1, 1'b1, 1'b1);  // three ranks, gap at rank 1
    run(32'h00_00_00_00, 2'd0, 2'd0, 1'b0, 1'b0);  // base target only
    run(32'hFF_00_00_40, 2'd3, 2'd3, 1'b1, 1'b0);  // field shifted out, top field
    run(32'h3F_00_00_00, 2'd1, 2'd2, 1'b0, 1'b0);  // last rank only
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual still running, expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule